// File: doc/BRIEF.md
# Dual-Bus Bidirectional Shift Register

This block is an eight-stage register placed between two 8-bit parallel buses, A and B. It also has a dedicated serial data input. A direction select sets which bus supplies data and which bus receives the register contents. The block can carry words from A to B or from B to A. It can gather serial bits and present them as a parallel word. It can take a word from either bus and shift it out one bit at a time. It can also hold its contents unchanged. Each bus is modelled with separate input, output and output-enable signals, so the pad-level tri-state is left to the chip around it.

Everything runs on one system clock with a synchronous active-high reset. The external shift clock is sampled and its rising edge is detected, so each detected edge produces one shift or one clocked load. Parallel loads come in two modes. In clocked mode a load waits for a shift-clock edge. In free-running mode a load happens on every system clock cycle while parallel mode is selected. The A-bus enable gates both loading from A and driving onto A. When A is the input side and its enable is off, a parallel operation recirculates the stored word, which keeps it unchanged.

Top module: `dbsr_top`

## Requirements
- R1: After reset, all eight stages hold zero, so `a_out`, `b_out` and `ser_o` read zero.
- R2: In serial mode (`par_i`=0), each detected rising edge of `shclk_i` moves stage k to stage k+1 and places `ser_i` in stage 0. Bit k of the outputs is stage k.
- R3: `ser_o` always equals stage 7, the most significant bit of the stored word.
- R4: In parallel mode with `async_i`=0, `dir_i`=1 and `a_en_i`=1, a detected shift-clock edge loads `a_in`.
- R5: In parallel mode with `dir_i`=0, the word on `b_in` is loaded. The load happens on a shift-clock edge when `async_i`=0, and on every cycle when `async_i`=1.
- R6: In parallel mode with `async_i`=1, a load happens every system clock cycle, whether or not the shift clock has an edge.
- R7: In parallel mode with `dir_i`=1 and `a_en_i`=0, the stored word is kept unchanged in both load modes.
- R8: `b_oe` equals `dir_i`. `a_oe` equals the inverse of `dir_i` ANDed with `a_en_i`. Both outputs carry the stored word.
- R9: A word loaded in parallel and then shifted in serial mode appears at `ser_o` most significant bit first, one bit per shift-clock edge.
- R10: Holding `shclk_i` high produces no further shift or clocked load after the first cycle of the edge. In serial mode with no edge, the contents hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shclk_i | input | 1 | Shift clock, sampled and edge-detected |
| a_en_i | input | 1 | A-bus enable for loading and driving |
| async_i | input | 1 | 1: load every cycle in parallel mode; 0: load on shift edge |
| dir_i | input | 1 | 1: A is input and B is output; 0: B is input and A is output |
| par_i | input | 1 | 1: parallel load; 0: serial shift |
| ser_i | input | 1 | Serial data into stage 0 |
| a_in | input | 8 | A-bus input word |
| a_out | output | 8 | A-bus output word |
| a_oe | output | 1 | A-bus output enable |
| b_in | input | 8 | B-bus input word |
| b_out | output | 8 | B-bus output word |
| b_oe | output | 1 | B-bus output enable |
| ser_o | output | 1 | Serial output (stage 7) |

## Verification
Some rules are checked on every cycle by the assertions: the stage-to-stage movement on a shift, the A-bus capture, the hold and recirculate paths, the single-cycle width of the detected shift edge, and the exclusive bus enables. Other behaviour only shows up over a sequence of cycles, so only the bench scenarios can confirm it. This covers the most-significant-bit-first stream produced by a load followed by shifts, the gap between clocked and free-running loads while the shift clock is held, and the zeroed contents after reset. Those scenarios are compared against a reference model inside the bench.

// File: rtl/dbsr_pkg.sv
package dbsr_pkg;

    localparam int unsigned STAGES = 8;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_SHIFT  = 2'd1,
        OP_LOAD_A = 2'd2,
        OP_LOAD_B = 2'd3
    } op_e;

    typedef struct packed {
        logic par;
        logic free_load;
        logic a_is_src;
        logic a_en;
    } ctrl_t;

    function automatic op_e pick_op(ctrl_t c, logic rise);
        op_e r;
        if (!c.par)
            r = rise ? OP_SHIFT : OP_HOLD;
        else if (!(c.free_load || rise))
            r = OP_HOLD;
        else if (c.a_is_src)
            r = c.a_en ? OP_LOAD_A : OP_HOLD;
        else
            r = OP_LOAD_B;
        return r;
    endfunction

endpackage

// File: rtl/dbsr_rise.sv
module dbsr_rise (
    input  logic clk,
    input  logic rst,
    input  logic sh_i,
    output logic rise_o
);
    logic sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= 1'b0;
        else     sh_q <= sh_i;
    end

    assign rise_o = sh_i & ~sh_q;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R10
endmodule

// File: rtl/dbsr_stages.sv
module dbsr_stages
    import dbsr_pkg::*;
#(
    parameter int unsigned W = STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  op_e          op,
    input  logic         ser_i,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic up;
        if (i == 0) begin : g_first
            assign up = ser_i;
        end else begin : g_rest
            assign up = q[i-1];
        end
        always_comb begin
            unique case (op)
                OP_SHIFT:  nxt[i] = up;
                OP_LOAD_A: nxt[i] = a_in[i];
                OP_LOAD_B: nxt[i] = b_in[i];
                default:   nxt[i] = q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (q == {$past(q[W-2:0]), $past(ser_i)})); // R2
    AST_LOAD_A: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD_A) |=> (q == $past(a_in))); // R4
    AST_LOAD_B: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD_B) |=> (q == $past(b_in))); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(q)); // R7
endmodule

// File: rtl/dbsr_bus.sv
module dbsr_bus #(
    parameter int unsigned W = dbsr_pkg::STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] q,
    input  logic         dir_i,
    input  logic         a_en_i,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         ser_o
);
    assign a_out = q;
    assign b_out = q;
    assign b_oe  = dir_i;
    assign a_oe  = ~dir_i & a_en_i;
    assign ser_o = q[W-1];

    AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe)); // R8
    AST_SER_TAP: assert property (@(posedge clk) disable iff (rst)
        ser_o == b_out[W-1]); // R3
endmodule

// File: rtl/dbsr_top.sv
module dbsr_top
    import dbsr_pkg::*;
#(
    parameter int unsigned W = STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shclk_i,
    input  logic         a_en_i,
    input  logic         async_i,
    input  logic         dir_i,
    input  logic         par_i,
    input  logic         ser_i,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         ser_o
);
    logic  rise;
    ctrl_t ctrl;
    op_e   op;
    logic [W-1:0] q;

    dbsr_rise u_rise (
        .clk    (clk),
        .rst    (rst),
        .sh_i   (shclk_i),
        .rise_o (rise)
    );

    always_comb begin
        ctrl.par       = par_i;
        ctrl.free_load = async_i;
        ctrl.a_is_src  = dir_i;
        ctrl.a_en      = a_en_i;
        op             = pick_op(ctrl, rise);
    end

    dbsr_stages #(.W(W)) u_stages (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .ser_i (ser_i),
        .a_in  (a_in),
        .b_in  (b_in),
        .q     (q)
    );

    dbsr_bus #(.W(W)) u_bus (
        .clk    (clk),
        .rst    (rst),
        .q      (q),
        .dir_i  (dir_i),
        .a_en_i (a_en_i),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_out  (b_out),
        .b_oe   (b_oe),
        .ser_o  (ser_o)
    );

    AST_RECIRC_KEEP: assert property (@(posedge clk) disable iff (rst)
        (par_i && dir_i && !a_en_i) |=> $stable(b_out)); // R7
    AST_FREE_LOAD_B: assert property (@(posedge clk) disable iff (rst)
        (par_i && async_i && !dir_i) |=> (a_out == $past(b_in))); // R6
endmodule

// File: tb/sim_dbsr_top.sv
module sim_dbsr_top;
    logic clk = 1'b0;
    logic rst, shclk_i, a_en_i, async_i, dir_i, par_i, ser_i;
    logic [7:0] a_in, b_in, a_out, b_out;
    logic a_oe, b_oe, ser_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_q;
    logic       m_sh;

    always #2 clk = ~clk;

    dbsr_top u0 (
        .clk(clk), .rst(rst), .shclk_i(shclk_i), .a_en_i(a_en_i),
        .async_i(async_i), .dir_i(dir_i), .par_i(par_i), .ser_i(ser_i),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ser_o(ser_o)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_next(logic [7:0] q, logic rise);
        if (!par_i) return rise ? {q[6:0], ser_i} : q;
        if (!(async_i || rise)) return q;
        if (dir_i) return a_en_i ? a_in : q;
        return b_in;
    endfunction

    function automatic string tag_of(logic rise);
        if (!par_i) return rise ? "R2" : "R10";
        if (dir_i && !a_en_i) return "R7";
        if (async_i) return "R6";
        if (!rise) return "R10";
        return dir_i ? "R4" : "R5";
    endfunction

    // inputs already set at a negedge; advance one cycle and compare
    task automatic step();
        logic rise;
        string t;
        rise = shclk_i & ~m_sh;
        t    = tag_of(rise);
        m_q  = model_next(m_q, rise);
        m_sh = shclk_i;
        @(posedge clk);
        @(negedge clk);
        check(t, b_out, m_q);
        check("R3", {7'b0, ser_o}, {7'b0, m_q[7]});
        check("R8", {6'b0, a_oe, b_oe}, {6'b0, ~dir_i & a_en_i, dir_i});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got;
        void'($urandom(32'd5021));
        rst = 1'b1; shclk_i = 0; a_en_i = 0; async_i = 0; dir_i = 0;
        par_i = 0; ser_i = 0; a_in = 8'h3C; b_in = 8'hC3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_q = '0; m_sh = 1'b0;
        check("R1", a_out, 8'h00);
        check("R1", {7'b0, ser_o}, 8'h00);

        // R9: clocked load from B, then serialise MSB first
        dir_i = 0; par_i = 1; async_i = 0; b_in = 8'hA5;
        shclk_i = 1; step(); shclk_i = 0; step();
        par_i = 0; ser_i = 0; got = '0;
        for (int i = 0; i < 8; i++) begin
            got = {got[6:0], ser_o};
            shclk_i = 1; step(); shclk_i = 0; step();
        end
        check("R9", got, 8'hA5);

        // R10: shift clock held high shifts once only
        ser_i = 1; shclk_i = 1;
        repeat (4) step();
        shclk_i = 0; step();

        // R4 then R7: load from A, then A disabled keeps it
        dir_i = 1; a_en_i = 1; par_i = 1; a_in = 8'h5E;
        shclk_i = 1; step(); shclk_i = 0; step();
        a_en_i = 0; async_i = 1; a_in = 8'hFF;
        repeat (2) step();
        shclk_i = 1; step(); shclk_i = 0;
        check("R7", a_out, 8'h5E);

        // R6: free-running load follows B without shift edges
        dir_i = 0; async_i = 1;
        for (int i = 0; i < 4; i++) begin
            b_in = 8'(i * 37 + 11); step();
        end

        // random mix
        for (int i = 0; i < 3000; i++) begin
            shclk_i = 1'($urandom);
            a_en_i  = 1'($urandom);
            async_i = ($urandom % 4) == 0;
            dir_i   = 1'($urandom);
            par_i   = ($urandom % 3) == 0;
            ser_i   = 1'($urandom);
            a_in    = 8'($urandom);
            b_in    = 8'($urandom);
            step();
        end

        // R1: reset in the middle of activity
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        m_q = '0; m_sh = 1'b0;
        check("R1", b_out, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule